// File: doc/BRIEF.md
# I2C Serial EEPROM Slave with Page Latch

This block is a two-wire bus slave in front of a small byte store of 128 locations. An oversampling system clock samples the serial clock and data lines through synchronisers. From these samples the block finds start and stop conditions, clocks bytes in and out, and drives an open-drain data output. The slave address has a fixed four-bit prefix `1010`, followed by three bits taken from strap inputs, so eight of these blocks can share one bus.

A write transfer carries the address byte with direction bit 0, then a word-address byte that loads the internal location counter, then data bytes. Data bytes are not written to the store straight away. They go into an eight-byte page latch, and the low three bits of the counter wrap inside the current page. A stop condition after at least one data byte starts a timed self-write cycle. That cycle copies every latched byte over its location and leaves no trace of the old content. While the cycle runs, the block does not acknowledge its address. A read transfer (direction bit 1) returns bytes from the counter onward. The counter wraps from the last location back to the first, so the master keeps reading until it withholds its acknowledge.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A byte written to any location through a write transfer followed by a stop is returned by a later read of that location.
- R2: The block answers only an address byte whose upper seven bits are `1010` followed by `strap_i[2:1:0]` (bit 0 of the byte: 1 = read, 0 = write). For any other address it leaves SDA released for that byte and for every clock until the next start.
- R3: In an addressed write transfer, every received byte is acknowledged: SDA is held low during the high phase of the ninth clock.
- R4: The byte after a write address loads the location counter. The counter advances by one after each byte written or read, and a current-address read returns the location the counter holds.
- R5: In a write transfer the low three counter bits wrap within the eight-byte page. When more than eight bytes are sent, the later bytes replace the earlier ones at the same page slot.
- R6: A stop that follows at least one data byte starts a self-write cycle of `WRITE_CYCLES` clocks. During this cycle the address is not acknowledged and SDA is not driven. After the cycle the address is acknowledged again.
- R7: A committed byte fully replaces the previous content of its location. No old bit survives, as if the location were erased first.
- R8: A read transfer returns consecutive locations for as long as the master acknowledges, and location 127 is followed by location 0.
- R9: When the master does not acknowledge a byte it has read, the block releases SDA and stays silent until a start or a stop.
- R10: A start seen at any point restarts address reception. Data bytes latched before a repeated start are dropped, so the following stop starts no self-write cycle.
- R11: After reset, SDA is released, the location counter is 0 and no self-write cycle is pending. Reset leaves the store contents unchanged.
- R12: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 3 | Low three slave address bits |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench checks an address that is not acknowledged during the self-write cycle. A design with a timer that is too short, or with no timer at all, would answer early. It writes past the end of a page and reads across location 127. A design that carried into the page number or stopped at the top would return bytes from the wrong locations. A repeated start after a latched byte, followed by a stop, must not start a cycle, so an address right after it must be acknowledged. A design that kept the stale latch would go silent there instead. After a master's not-acknowledge and after a foreign address, the bench watches SDA for any pull-low. It also checks that the counter returns to 0 across a reset while the stored data survive.

// File: rtl/i2c_ee_pkg.sv
// Shared types for the serial EEPROM slave: the bit-level bus state,
// the role of the byte being received and the fixed address prefix.
package i2c_ee_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // not addressed, waiting for a start
        ST_RX,      // shifting in a byte
        ST_ACK,     // driving the acknowledge bit
        ST_TX,      // shifting out a byte
        ST_MACK,    // sampling the master's acknowledge
        ST_TXLOAD   // loading the next byte to send
    } bus_state_t;

    typedef enum logic [1:0] {
        BK_DEV,     // slave address byte
        BK_WORD,    // word address byte
        BK_DATA     // write data byte
    } byte_kind_t;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

endpackage

// File: rtl/i2c_ee_sync.sv
// Line sampler: brings SCL and SDA into the clk domain through a
// synchroniser chain and flags clock edges, start and stop.
// Assumes clk runs many times faster than SCL, so each level lasts
// several clk cycles.
module i2c_ee_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic              scl_prev, sda_prev;
    logic              scl_s;

    // Synchroniser chains plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    // Edge and bus-condition decode from current and previous sample.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_prev;
        scl_fall  = ~scl_s & scl_prev;
        start_evt = scl_s & scl_prev & sda_prev & ~sda_s;
        stop_evt  = scl_s & scl_prev & ~sda_prev & sda_s;
    end

endmodule

// File: rtl/i2c_ee_proto.sv
// Bit and byte protocol engine: address match, acknowledge, location
// counter, write-data hand-off to the page latch and read shifting.
// Assumes a single master and clean line samples from i2c_ee_sync.
module i2c_ee_proto
    import i2c_ee_pkg::*;
#(
    parameter int AW = 7,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic [2:0]    strap_i,
    input  logic          busy,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] loc_ptr,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sda_drive_low
);
    bus_state_t state;
    byte_kind_t kind;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    logic [6:0] tx_rest;
    logic       is_read;
    logic       ack_half;
    logic [7:0] rx_byte;
    logic       dev_hit;

    // Byte under assembly and slave address comparison.
    always_comb begin
        rx_byte = {shreg, sda_s};
        dev_hit = (rx_byte[7:1] == {DEV_PREFIX, strap_i}) && !busy;
    end

    // Protocol state machine; start and stop take priority over edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            kind          <= BK_DEV;
            bit_cnt       <= '0;
            shreg         <= '0;
            tx_rest       <= '0;
            is_read       <= 1'b0;
            ack_half      <= 1'b0;
            loc_ptr       <= '0;
            wr_stb        <= 1'b0;
            wr_addr       <= '0;
            wr_data       <= '0;
            sda_drive_low <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (start_evt) begin
                state         <= ST_RX;
                kind          <= BK_DEV;
                bit_cnt       <= '0;
                is_read       <= 1'b0;
                sda_drive_low <= 1'b0;
            end else if (stop_evt) begin
                state         <= ST_IDLE;
                sda_drive_low <= 1'b0;
            end else begin
                case (state)
                    ST_RX: if (scl_rise) begin
                        shreg   <= rx_byte[6:0];
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            ack_half <= 1'b0;
                            state    <= ST_ACK;
                            case (kind)
                                BK_DEV: begin
                                    is_read <= rx_byte[0];
                                    if (!dev_hit) state <= ST_IDLE;
                                end
                                BK_WORD: loc_ptr <= rx_byte[AW-1:0];
                                default: begin
                                    wr_stb  <= 1'b1;
                                    wr_addr <= loc_ptr;
                                    wr_data <= rx_byte;
                                    loc_ptr <= {loc_ptr[AW-1:PW],
                                                loc_ptr[PW-1:0] + PW'(1)};
                                end
                            endcase
                        end
                    end
                    ST_ACK: if (scl_fall) begin
                        if (!ack_half) begin
                            sda_drive_low <= 1'b1;
                            ack_half      <= 1'b1;
                        end else if (kind == BK_DEV && is_read) begin
                            tx_rest       <= rd_data[6:0];
                            sda_drive_low <= ~rd_data[7];
                            bit_cnt       <= '0;
                            state         <= ST_TX;
                        end else begin
                            sda_drive_low <= 1'b0;
                            bit_cnt       <= '0;
                            kind          <= (kind == BK_DEV) ? BK_WORD : BK_DATA;
                            state         <= ST_RX;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            if (bit_cnt == 3'd7) begin
                                state   <= ST_MACK;
                                loc_ptr <= loc_ptr + AW'(1);
                            end
                            bit_cnt <= bit_cnt + 3'd1;
                        end
                        if (scl_fall) begin
                            sda_drive_low <= ~tx_rest[6];
                            tx_rest       <= {tx_rest[5:0], 1'b0};
                        end
                    end
                    ST_MACK: begin
                        if (scl_fall) sda_drive_low <= 1'b0;
                        if (scl_rise) state <= sda_s ? ST_IDLE : ST_TXLOAD;
                    end
                    ST_TXLOAD: if (scl_fall) begin
                        tx_rest       <= rd_data[6:0];
                        sda_drive_low <= ~rd_data[7];
                        bit_cnt       <= '0;
                        state         <= ST_TX;
                    end
                    default: sda_drive_low <= 1'b0;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_ee_store.sv
// Byte store with an eight-slot page latch and a self-write timer.
// Latched bytes are copied over their locations when the timer ends;
// a start outside the cycle drops the latch. The array itself is not
// reset, so its content survives a reset of the control logic.
module i2c_ee_store #(
    parameter int DEPTH        = 128,
    parameter int PAGE         = 8,
    parameter int WRITE_CYCLES = 2000,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = $clog2(PAGE),
    localparam int TW = $clog2(WRITE_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy
);
    logic [7:0]     mem [DEPTH];
    logic [7:0]     slot_data [PAGE];
    logic           slot_full [PAGE];
    logic [AW-PW-1:0] page_sel;
    logic [TW-1:0]  timer;
    logic           commit_now;
    logic           any_full;

    // Commit strobe and any-slot-filled reduction.
    always_comb begin
        commit_now = busy && (timer == '0);
        any_full   = 1'b0;
        for (int i = 0; i < PAGE; i++) any_full = any_full | slot_full[i];
        rd_data    = mem[rd_addr];
    end

    // One latch slot per page byte: fill on write, clear on drop/commit.
    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_full[g] <= 1'b0;
                slot_data[g] <= '0;
            end else if (commit_now || (start_evt && !busy)) begin
                slot_full[g] <= 1'b0;
            end else if (wr_stb && wr_addr[PW-1:0] == PW'(g)) begin
                slot_full[g] <= 1'b1;
                slot_data[g] <= wr_data;
            end
        end
    end

    // Page number of the latched bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)      page_sel <= '0;
        else if (wr_stb) page_sel <= wr_addr[AW-1:PW];
    end

    // Self-write timer: armed by a stop with latched data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            timer <= '0;
        end else if (busy) begin
            if (timer == '0) busy <= 1'b0;
            else             timer <= timer - TW'(1);
        end else if (stop_evt && any_full) begin
            busy  <= 1'b1;
            timer <= TW'(WRITE_CYCLES - 1);
        end
    end

    // Array update: each latched byte overwrites its whole location.
    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE; i++) begin
            if (commit_now && slot_full[i]) mem[{page_sel, PW'(i)}] <= slot_data[i];
        end
    end

endmodule

// File: rtl/i2c_eeprom_slave.sv
// Top level of the serial EEPROM slave: line sampler, protocol engine
// and page-latched store. DEPTH and PAGE must be powers of two and
// clk must be at least ten times faster than SCL.
module i2c_eeprom_slave #(
    parameter int DEPTH        = 128,
    parameter int PAGE         = 8,
    parameter int WRITE_CYCLES = 2000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_drive_low
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);

    logic          sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic          busy, wr_stb;
    logic [AW-1:0] loc_ptr, wr_addr;
    logic [7:0]    wr_data, rd_data;

    i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2c_ee_proto #(.AW(AW), .PW(PW)) u_proto (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .strap_i(strap_i), .busy(busy), .rd_data(rd_data),
        .loc_ptr(loc_ptr), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .sda_drive_low(sda_drive_low)
    );

    i2c_ee_store #(.DEPTH(DEPTH), .PAGE(PAGE), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .start_evt(start_evt), .stop_evt(stop_evt),
        .rd_addr(loc_ptr), .rd_data(rd_data), .busy(busy)
    );

endmodule

// File: rtl/i2c_ee_checker.sv
// Protocol checker bound to the slave top: drive timing against SCL,
// silence during the self-write cycle and the cycle's length.
module i2c_ee_checker #(
    parameter int WRITE_CYCLES = 2000,
    localparam int CW = $clog2(WRITE_CYCLES + 2)
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_drive_low,
    input logic busy,
    input logic stop_evt
);
    logic [CW-1:0] busy_len;

    // Independent count of consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) busy_len <= '0;
        else                 busy_len <= busy_len + CW'(1);
    end

    // R12: the drive changes only while the clock line is low.
    p_drive_edge_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low)) |-> !scl_i);

    // R6: no pull-low while the self-write cycle runs.
    p_silent_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_drive_low);

    // R6: the cycle lasts exactly WRITE_CYCLES clocks.
    p_cycle_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == CW'(WRITE_CYCLES)));

    // R6: the cycle is only started by a stop condition.
    p_cycle_after_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt));

    // R9: a stop always leaves the line released.
    p_stop_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_drive_low);

endmodule

bind i2c_eeprom_slave i2c_ee_checker #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_drive_low(sda_drive_low),
    .busy(busy), .stop_evt(stop_evt)
);

// File: tb/i2c_eeprom_slave_tb.sv
// Scoreboard bench: bus tasks act as master, read bytes go to a queue
// that a monitor compares against expected bytes from a reference store.
module i2c_eeprom_slave_tb;
    localparam int WC = 400;
    localparam int Q  = 8;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [6:0] DEV = {4'b1010, STRAP};

    typedef struct { logic [7:0] v; string req; } item_t;

    logic clk = 0, rst_n = 0, scl_line = 1, m_sda = 1;
    logic [2:0] strap = STRAP;
    logic sda_drive_low, sda_line;
    logic [7:0] ref_mem [128];
    logic [6:0] ref_ptr;
    logic [7:0] wbuf [16];
    item_t exp_q[$];
    logic [7:0] act_q[$];
    int n_chk = 0, n_fail = 0, r12_bad = 0;
    bit drove = 0, done = 0, last_oe = 0;

    assign sda_line = m_sda & ~sda_drive_low;
    always #10 clk = ~clk;

    i2c_eeprom_slave #(.WRITE_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .strap_i(strap), .sda_drive_low(sda_drive_low)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive watcher and R12 monitor of drive changes against SCL.
    always @(negedge clk) begin
        if (sda_drive_low) drove = 1;
        if (rst_n && sda_drive_low != last_oe && scl_line) r12_bad++;
        last_oe = sda_drive_low;
    end

    // Scoreboard monitor: compare each read byte with the expected one.
    initial forever begin
        @(negedge clk);
        while (act_q.size() > 0) begin
            item_t e;
            logic [7:0] a;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            chk(e.req, a, e.v);
        end
    end

    task automatic qw(); repeat (Q) @(negedge clk); endtask

    task automatic bstart();
        m_sda = 1; qw(); scl_line = 1; qw(); m_sda = 0; qw(); scl_line = 0; qw();
    endtask

    task automatic bstop();
        m_sda = 0; qw(); scl_line = 1; qw(); m_sda = 1; qw();
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; qw(); scl_line = 1; qw(); qw(); scl_line = 0; qw();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1; qw(); scl_line = 1; qw();
        ack = !sda_line;
        qw(); scl_line = 0; qw();
    endtask

    task automatic read_byte(input bit more, input string req);
        logic [7:0] v;
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl_line = 1; qw(); v[i] = sda_line; qw(); scl_line = 0; qw();
        end
        m_sda = more ? 1'b0 : 1'b1;
        qw(); scl_line = 1; qw(); qw(); scl_line = 0; qw(); m_sda = 1;
        exp_q.push_back('{ref_mem[ref_ptr], req});
        act_q.push_back(v);
        ref_ptr = ref_ptr + 7'd1;
    endtask

    // Write wbuf[0..n-1] from word address; reference follows page wrap.
    task automatic do_write(input logic [6:0] word, input int n, input bit wait_c);
        logic ack;
        bstart();
        send_byte({DEV, 1'b0}, ack); chk("R2 address ack", ack, 1);
        send_byte({1'b0, word}, ack); chk("R3 word ack", ack, 1);
        ref_ptr = word;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ack); chk("R3 data ack", ack, 1);
            ref_mem[ref_ptr] = wbuf[k];
            ref_ptr = {ref_ptr[6:3], ref_ptr[2:0] + 3'd1};
        end
        bstop();
        if (wait_c) repeat (WC + 40) @(negedge clk);
    endtask

    task automatic rand_read(input logic [6:0] word, input int n, input string req);
        logic ack;
        bstart();
        send_byte({DEV, 1'b0}, ack); chk("R2 address ack", ack, 1);
        send_byte({1'b0, word}, ack); chk("R4 word ack", ack, 1);
        ref_ptr = word;
        bstart();
        send_byte({DEV, 1'b1}, ack); chk("R2 read address ack", ack, 1);
        for (int k = 0; k < n; k++) read_byte(k < n - 1, req);
        bstop();
    endtask

    initial begin
        logic ack;
        repeat (5) @(negedge clk);
        chk("R11 released in reset", sda_drive_low, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        chk("R11 released after reset", sda_drive_low, 0);

        // R11: counter returns to 0 over reset, contents kept.
        for (int k = 0; k < 4; k++) wbuf[k] = 8'h90 + 8'(k);
        do_write(7'h00, 4, 1);
        rst_n = 0; repeat (4) @(negedge clk); rst_n = 1; repeat (4) @(negedge clk);
        ref_ptr = 7'h00;
        bstart();
        send_byte({DEV, 1'b1}, ack); chk("R11 read address ack", ack, 1);
        read_byte(0, "R11 counter at zero");
        bstop();

        // R1/R6: single write, silence during the cycle, then read back.
        wbuf[0] = 8'hA5;
        do_write(7'h10, 1, 0);
        bstart(); drove = 0;
        send_byte({DEV, 1'b0}, ack);
        chk("R6 no ack while busy", ack, 0);
        chk("R6 no drive while busy", drove, 0);
        bstop();
        repeat (WC + 40) @(negedge clk);
        bstart();
        send_byte({DEV, 1'b0}, ack); chk("R6 ack after cycle", ack, 1);
        bstop();
        rand_read(7'h10, 1, "R1 random read");

        // R4/R8: full page then sequential read.
        for (int k = 0; k < 8; k++) wbuf[k] = 8'h20 + 8'(k * 3);
        do_write(7'h20, 8, 1);
        rand_read(7'h20, 8, "R8 sequential read");

        // R5/R4: page wrap from 0x26, then current-address read.
        for (int k = 0; k < 4; k++) wbuf[k] = 8'hC0 + 8'(k);
        do_write(7'h26, 4, 1);
        bstart();
        send_byte({DEV, 1'b1}, ack); chk("R4 read address ack", ack, 1);
        read_byte(0, "R4 current address after write");
        bstop();
        rand_read(7'h20, 8, "R5 page wrap");

        // R5: ten bytes into one page overwrite the first two slots.
        for (int k = 0; k < 10; k++) wbuf[k] = 8'h50 + 8'(k * 7);
        do_write(7'h30, 10, 1);
        rand_read(7'h30, 8, "R5 overlong page");

        // R7: new content fully replaces old.
        wbuf[0] = 8'hF0; do_write(7'h40, 1, 1);
        wbuf[0] = 8'h0F; do_write(7'h40, 1, 1);
        rand_read(7'h40, 1, "R7 full replace");

        // R8: read across the top of the store.
        for (int k = 0; k < 8; k++) wbuf[k] = 8'h70 + 8'(k);
        do_write(7'h78, 8, 1);
        rand_read(7'h7E, 4, "R8 wrap 127 to 0");

        // R2: foreign addresses and following bytes stay unanswered.
        bstart(); drove = 0;
        send_byte({4'b1010, 3'b000, 1'b0}, ack);
        chk("R2 wrong strap no ack", ack, 0);
        send_byte(8'h00, ack);
        chk("R2 ignored until start", drove, 0);
        bstart(); drove = 0;
        send_byte({4'b0101, STRAP, 1'b1}, ack);
        chk("R2 wrong prefix silent", drove, 0);
        bstop();

        // R9: master withholds ack, slave stays silent.
        rand_read(7'h20, 1, "R9 last byte");
        drove = 0;
        bstart();
        send_byte({DEV, 1'b1}, ack); chk("R9 address ack", ack, 1);
        read_byte(0, "R9 byte before nack");
        drove = 0;
        for (int i = 0; i < 9; i++) send_bit(1'b1);
        chk("R9 silent after nack", drove, 0);
        bstop();

        // R10: repeated start drops latched data; no cycle follows.
        wbuf[0] = 8'h77; do_write(7'h50, 1, 1);
        bstart();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h50, ack);
        send_byte(8'h11, ack); chk("R10 data latched ack", ack, 1);
        rand_read(7'h50, 1, "R10 latch not visible");
        bstart();
        send_byte({DEV, 1'b0}, ack); chk("R10 no cycle after drop", ack, 1);
        bstop();
        rand_read(7'h50, 1, "R10 store unchanged");

        // R10: start in the middle of a byte restarts address reception.
        bstart();
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bstart();
        send_byte({DEV, 1'b0}, ack); chk("R10 mid-byte restart", ack, 1);
        bstop();

        chk("R12 drive changes with SCL low", r12_bad, 0);
        repeat (10) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(negedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule